// File: doc/BRIEF.md
# Rising-Edge Trigger Enable Register with Per-Line Access Filtering

This block holds the rising-edge trigger enables for a bank of 32 external event lines, numbered 32 to 63. Line n is controlled by register bit n-32. Only a sparse subset of the lines is configurable, given by a parameter mask; by default these are lines 46, 50 and 53, at bits 14, 18 and 21. An enabled line produces a one-cycle pulse, used for both event and interrupt generation, whenever a rising edge is seen on its input.

Every configurable bit has its own security attribute input and its own privilege attribute input. These decide whether the current bus access may see or change that bit. Each access on the single-cycle register port carries a secure flag and a privileged flag. A bit that an access may not touch is dropped from a write without any error, and it reads back as zero. Bits in the same access that pass their own checks behave normally.

Top module: `rtrig_cfg_reg`

## Requirements
- R1: After reset every enable bit is 0, so a fully permitted read returns 0 and no trigger pulse is produced.
- R2: A write with both the secure and privileged flags set updates every configurable bit (bits 14, 18 and 21 by default). A read with the same flags returns the stored values.
- R3: Register bits with no configurable line always read as 0, and writes to them have no effect.
- R4: When a line's security attribute is 1, a write with the secure flag at 0 leaves that line's bit unchanged.
- R5: When a line's security attribute is 1, a read with the secure flag at 0 returns 0 in that line's bit.
- R6: When a line's privilege attribute is 1, a write with the privileged flag at 0 leaves that line's bit unchanged.
- R7: When a line's privilege attribute is 1, a read with the privileged flag at 0 returns 0 in that line's bit.
- R8: The checks are made per bit. In a single write, every bit whose own checks pass takes its write data, whatever happens to the blocked bits.
- R9: When both attributes of a line are 0, its bit can be written and read by any combination of the secure and privileged flags.
- R10: For an enabled line, a line input that is sampled 0 at one clock edge and 1 at the next produces a pulse on that line's output. The pulse lasts for exactly the one cycle that follows the second edge.
- R11: A line whose enable bit is 0, or a line that is not configurable, never produces a pulse.
- R12: While the select input is low, the write enable has no effect and the read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Address match for this register |
| bus_we | input | 1 | Write enable, qualified by bus_sel |
| bus_wdata | input | 32 | Write data, bit k belongs to line 32+k |
| bus_rdata | output | 32 | Filtered read data, valid while bus_sel is high |
| bus_secure | input | 1 | Access is secure |
| bus_priv | input | 1 | Access is privileged |
| line_sec_attr | input | 32 | Per-line security attribute |
| line_priv_attr | input | 32 | Per-line privilege attribute |
| line_in | input | 32 | Synchronous event line levels |
| trig_pulse | output | 32 | Per-line rising-edge trigger pulse |

## Verification
The hardest case to reach is a single write in which some configurable bits are blocked and others are accepted, and in which a bit may be blocked by security, by privilege or by both. The stimulus sweeps every combination of the six attribute bits of the three configurable lines against all four combinations of the access flags. For each combination it clears or fills the register with a fully permitted write, applies the opposite data with the restricted access, and reads the result back. It then reads the register again with the restricted flags to check the read filtering. Edge pulses are checked by raising enabled, disabled and non-configurable lines at known edges and sampling the output in the following cycle.

// File: rtl/rtrig_pkg.sv
package rtrig_pkg;
    localparam int REG_W = 32;
    typedef logic [REG_W-1:0] word_t;

    typedef struct packed {
        word_t cfg;
    } store_state_t;

    typedef struct packed {
        word_t samp;
        word_t prev;
    } edge_state_t;
endpackage

// File: rtl/rtrig_access_filter.sv
module rtrig_access_filter
    import rtrig_pkg::*;
#(
    parameter word_t IMPL_MASK = 32'h0024_4000
) (
    input  logic  acc_secure,
    input  logic  acc_priv,
    input  word_t sec_attr,
    input  word_t priv_attr,
    output word_t allow
);
    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (IMPL_MASK[i]) begin : g_impl
            logic sec_ok;
            logic priv_ok;
            always_comb begin
                sec_ok   = !sec_attr[i] || acc_secure;
                priv_ok  = !priv_attr[i] || acc_priv;
                allow[i] = sec_ok && priv_ok;
            end
        end else begin : g_none
            assign allow[i] = 1'b0;
        end
    end
endmodule

// File: rtl/rtrig_cfg_store.sv
module rtrig_cfg_store
    import rtrig_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  word_t wr_data,
    input  word_t allow,
    output word_t cfg_q
);
    store_state_t st_d, st_q;
    word_t        wmask;

    always_comb begin
        st_d  = st_q;
        wmask = wr_en ? allow : '0;
        st_d.cfg = (st_q.cfg & ~wmask) | (wr_data & wmask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_q = st_q.cfg;

    AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((cfg_q & $past(allow)) == ($past(wr_data) & $past(allow)))); // R8
    AST_BLOCKED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((cfg_q & ~$past(allow)) == ($past(cfg_q) & ~$past(allow)))); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_q)); // R12
endmodule

// File: rtl/rtrig_edge_detect.sv
module rtrig_edge_detect
    import rtrig_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  word_t lines,
    input  word_t enable,
    output word_t pulse
);
    edge_state_t ed_d, ed_q;

    always_comb begin
        ed_d      = ed_q;
        ed_d.samp = lines;
        ed_d.prev = ed_q.samp;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ed_q <= '0;
        else        ed_q <= ed_d;
    end

    assign pulse = ed_q.samp & ~ed_q.prev & enable;
endmodule

// File: rtl/rtrig_cfg_reg.sv
module rtrig_cfg_reg
    import rtrig_pkg::*;
#(
    parameter word_t IMPL_MASK = 32'h0024_4000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        bus_secure,
    input  logic        bus_priv,
    input  logic [31:0] line_sec_attr,
    input  logic [31:0] line_priv_attr,
    input  logic [31:0] line_in,
    output logic [31:0] trig_pulse
);
    word_t allow;
    word_t cfg_q;
    logic  wr_en;

    assign wr_en = bus_sel && bus_we;

    rtrig_access_filter #(.IMPL_MASK(IMPL_MASK)) u_filter (
        .acc_secure (bus_secure),
        .acc_priv   (bus_priv),
        .sec_attr   (line_sec_attr),
        .priv_attr  (line_priv_attr),
        .allow      (allow)
    );

    rtrig_cfg_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (bus_wdata),
        .allow   (allow),
        .cfg_q   (cfg_q)
    );

    rtrig_edge_detect u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lines  (line_in),
        .enable (cfg_q),
        .pulse  (trig_pulse)
    );

    always_comb begin
        bus_rdata = bus_sel ? (cfg_q & allow) : '0;
    end

    AST_READ_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~(cfg_q & allow)) == '0); // R5
    AST_PULSE_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_pulse & ~$past(line_in)) == '0); // R10
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_pulse & $past(trig_pulse)) == '0); // R10
    AST_PULSE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_pulse & ~IMPL_MASK) == '0); // R11
endmodule

// File: tb/tb_rtrig_cfg_reg.sv
`timescale 1ns/1ps
module tb_rtrig_cfg_reg;
    localparam logic [31:0] IMPL = 32'h0024_4000;
    localparam int B0 = 14, B1 = 18, B2 = 21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        bus_secure = 1'b0, bus_priv = 1'b0;
    logic [31:0] line_sec_attr = '0, line_priv_attr = '0, line_in = '0;
    logic [31:0] trig_pulse;

    int errors = 0, checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rtrig_cfg_reg #(.IMPL_MASK(IMPL)) dut (.*);

    function automatic logic [31:0] spread(input logic [2:0] v);
        logic [31:0] r = 32'hA5A5_A5A5 & ~IMPL;
        r[B0] = v[0]; r[B1] = v[1]; r[B2] = v[2];
        return r;
    endfunction

    function automatic logic [31:0] allowed(input logic s, input logic p,
                                            input logic [31:0] ls, input logic [31:0] lp);
        return IMPL & (~ls | {32{s}}) & (~lp | {32{p}});
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d, input logic s, input logic p);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_wdata = d; bus_secure = s; bus_priv = p;
        @(negedge clk);
        bus_sel = 0; bus_we = 0; bus_wdata = '0;
    endtask

    task automatic rd(input logic s, input logic p, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_secure = s; bus_priv = p;
        #1 v = bus_rdata;
        bus_sel = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        rd(1, 1, v); check(v, '0, "R1 reset read");
        check(trig_pulse, '0, "R1 reset pulse");

        // R2 R3: full access write and read
        wr(32'hFFFF_FFFF, 1, 1); rd(1, 1, v); check(v, IMPL, "R2 R3 full write ones");
        wr(32'h0000_4000, 1, 1); rd(1, 1, v); check(v, 32'h0000_4000, "R2 single bit");

        // R12: select low
        @(negedge clk);
        bus_sel = 0; bus_we = 1; bus_wdata = 32'hFFFF_FFFF; bus_secure = 1; bus_priv = 1;
        #1 check(bus_rdata, '0, "R12 rdata when unselected");
        @(negedge clk); bus_we = 0;
        rd(1, 1, v); check(v, 32'h0000_4000, "R12 write ignored");

        // Sweep of access flags against all attribute combinations: R3 R4 R5 R6 R7 R8 R9
        for (int a = 0; a < 4; a++) begin
            for (int ap = 0; ap < 64; ap++) begin
                logic s = a[0];
                logic p = a[1];
                logic [31:0] al;
                line_sec_attr  = spread(ap[2:0]);
                line_priv_attr = spread(ap[5:3]);
                al = allowed(s, p, line_sec_attr, line_priv_attr);
                wr('0, 1, 1);
                wr(32'hFFFF_FFFF, s, p);
                rd(1, 1, v); check(v, al, "R4 R6 R8 R9 R3 restricted write ones");
                wr(32'hFFFF_FFFF, 1, 1);
                wr('0, s, p);
                rd(1, 1, v); check(v, IMPL & ~al, "R4 R6 R8 restricted write zeros");
                wr(32'hFFFF_FFFF, 1, 1);
                rd(s, p, v); check(v, al, "R5 R7 R9 restricted read");
            end
        end
        line_sec_attr = '0; line_priv_attr = '0;

        // R10 R11: edges; enable only line 46 (bit 14)
        wr(32'h0000_4000, 1, 1);
        @(negedge clk); line_in = '0;
        @(negedge clk);
        line_in = 32'h0004_4001; // bit14 enabled, bit18 disabled, bit0 not configurable
        @(negedge clk); check(trig_pulse, 32'h0000_4000, "R10 R11 pulse after edge");
        @(negedge clk); check(trig_pulse, '0, "R10 pulse lasts one cycle");
        @(negedge clk); check(trig_pulse, '0, "R10 held high no pulse");
        line_in = '0;
        @(negedge clk); check(trig_pulse, '0, "R10 falling no pulse");
        wr(32'h0020_0000, 1, 1); // enable line 53 only
        @(negedge clk); line_in = 32'h0020_4000;
        @(negedge clk); check(trig_pulse, 32'h0020_0000, "R10 R11 second line pulse");
        @(negedge clk); check(trig_pulse, '0, "R10 second pulse ends");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule